// File: doc/BRIEF.md
# Serial TDM Audio Frame Receiver

This block deserialises a time-division audio link carried on one data wire. A frame of 256 bits is made of one 16-bit tag slot (slot 0) and then twelve 20-bit data slots (slots 1 to 12), packed back to back with no gaps. A separate frame-sync wire marks where a frame starts. The receiver counts bits from that mark and steers each bit into the shift register of the slot that owns that bit position. When the final bit arrives, it publishes all thirteen slot words together and pulses a completion strobe.

The tag slot is also decoded into a frame-valid flag and a 12-bit mask that tells downstream logic which data slots hold payload. A sync edge that arrives before a frame has finished discards the partial frame, raises a sticky framing-error flag and starts a fresh frame at that bit.

The control is a two-state machine. HUNT waits for a sync rise and ignores serial bits. RECV captures one bit per cycle. Three transitions are named. SYNC_START goes from HUNT to RECV on a sync rise. FRAME_END goes from RECV back to HUNT after bit 255. RESYNC loops from RECV to RECV on a sync rise seen in the middle of a frame.

Top module: `tdm_frame_rx`

## Requirements
- R1: While `rst` is sampled high, and after it is released, `frame_done`, `frame_err`, `tag_slot`, `data_slots`, `frame_valid` and `slot_valid` are all zero until the first frame completes.
- R2: Frame bit 0 to 15 belong to slot 0 (`tag_slot`). Slot k (k = 1..12) owns frame bits 16+20(k-1) up to 35+20(k-1) and is output on `data_slots[20(k-1) +: 20]`. A frame is 256 bits long.
- R3: Within each slot the first bit received is the slot's most significant bit.
- R4: `sdata_in` and `sync_in` are sampled on the falling edge of `bit_clk`, one bit per period. A transmitter that changes the line just after the rising edge is captured correctly.
- R5: A sync rise means `sync_in` is sampled high where the previous sample was low. The bit sampled at that same falling edge is frame bit 0, which is bit 15 of slot 0. Serial bits sampled in HUNT are ignored.
- R6: `frame_done` goes high on the falling edge that samples frame bit 255 and stays high for exactly one `bit_clk` period. All slot outputs take their new values on that same edge.
- R7: Between completed frames, all slot outputs and decoded flags hold their values, whatever is on `sdata_in`.
- R8: A slot transmitted as all zeros is output as zero, even when the previous frame held non-zero data in it.
- R9: `frame_valid` equals `tag_slot[15]`. `slot_valid[k-1]` equals `tag_slot[15-k]` for k = 1..12.
- R10: A sync rise seen in RECV discards the partial frame (no `frame_done`, outputs unchanged), sets `frame_err`, and takes that bit as frame bit 0 of a new frame.
- R11: A new frame may begin on the bit right after bit 255 of the previous one, and both frames complete.
- R12: `frame_err` stays set until reset. Later good frames do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; the receiver acts on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Frame-sync; a rise marks frame bit 0 |
| sdata_in | input | 1 | Serial data, one bit per period, MSB first per slot |
| tag_slot | output | 16 | Last completed slot 0 word |
| data_slots | output | 240 | Last completed slots 1..12, slot k at bits 20(k-1) +: 20 |
| frame_valid | output | 1 | Tag bit 15 of the last completed frame |
| slot_valid | output | 12 | Per-slot valid mask decoded from the tag |
| frame_done | output | 1 | One-period strobe when a frame completes |
| frame_err | output | 1 | Sticky flag: a sync arrived mid-frame |

## Verification
The bench drives each bit 1 ns after a rising edge, so the falling edge half a period later captures it. Frame bit 255 is therefore captured at the falling edge after the 256th drive. `frame_done` and the slot words are already valid at the next rising edge, and the bench samples them there. The bench checks `frame_done` low again one rising edge later. For runs where pulses cannot be observed one by one, such as back-to-back frames, partial frames and idle stretches, a monitor counts strobes at rising edges, and the bench compares the count before and after each stimulus.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_t;
endpackage

// File: rtl/tdm_rx_tracker.sv
module tdm_rx_tracker
    import tdm_rx_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int DATA_W = 20,
    parameter int N_DATA = 12,
    localparam int FRAME_BITS = TAG_W + N_DATA * DATA_W,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              sync_in,
    output logic              cap_en,
    output logic [N_DATA:0]   slot_sel,
    output logic              last_bit,
    output logic              frame_err
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    rx_state_t        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx, pos;
    logic [31:0]      pos_ext;
    logic             sync_q, sync_rise, err_nx;

    assign sync_rise = sync_in & ~sync_q;
    assign pos_ext   = 32'(pos);

    // state register process
    always_ff @(negedge bit_clk) begin
        if (rst) begin
            state_q   <= ST_HUNT;
            cnt_q     <= '0;
            sync_q    <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            state_q   <= state_nx;
            cnt_q     <= cnt_nx;
            sync_q    <= sync_in;
            frame_err <= err_nx;
        end
    end

    // next-state and output process
    always_comb begin
        state_nx = state_q;
        cap_en   = 1'b0;
        pos      = cnt_q;
        err_nx   = frame_err;
        unique case (state_q)
            ST_HUNT: begin
                if (sync_rise) begin          // SYNC_START
                    state_nx = ST_RECV;
                    cap_en   = 1'b1;
                    pos      = '0;
                end
            end
            ST_RECV: begin
                cap_en = 1'b1;
                if (sync_rise) begin          // RESYNC
                    pos    = '0;
                    err_nx = 1'b1;
                end else if (cnt_q == LAST_POS) begin
                    state_nx = ST_HUNT;       // FRAME_END
                end
            end
        endcase
        last_bit = cap_en && (pos == LAST_POS);
        if (!cap_en)       cnt_nx = cnt_q;
        else if (last_bit) cnt_nx = '0;
        else               cnt_nx = pos + 1'b1;
    end

    // slot ownership from fixed bit offsets
    for (genvar k = 0; k <= N_DATA; k++) begin : g_bound
        localparam int LO = (k == 0) ? 0 : TAG_W + (k - 1) * DATA_W;
        localparam int HI = (k == 0) ? TAG_W : TAG_W + k * DATA_W;
        assign slot_sel[k] = (pos_ext >= LO) && (pos_ext < HI);
    end

    assert_resync_restart_R10: assert property (@(negedge bit_clk) disable iff (rst)
        (state_q == ST_RECV && sync_rise) |=> (frame_err && cnt_q == CNT_W'(1)));
    assert_err_sticky_R12: assert property (@(negedge bit_clk) disable iff (rst)
        frame_err |=> frame_err);
    assert_hunt_ignores_R5: assert property (@(negedge bit_clk) disable iff (rst)
        (state_q == ST_HUNT && !sync_rise) |=> (cnt_q == '0 && state_q == ST_HUNT));
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
    parameter int TAG_W  = 16,
    parameter int DATA_W = 20,
    parameter int N_DATA = 12
) (
    input  logic                     bit_clk,
    input  logic                     rst,
    input  logic                     sdata_in,
    input  logic                     cap_en,
    input  logic [N_DATA:0]          slot_sel,
    input  logic                     last_bit,
    output logic [TAG_W-1:0]         tag_slot,
    output logic [N_DATA*DATA_W-1:0] data_slots,
    output logic                     frame_done
);
    for (genvar k = 0; k <= N_DATA; k++) begin : g_slot
        localparam int W = (k == 0) ? TAG_W : DATA_W;
        logic [W-1:0] work_q, work_nx, hold_q;

        always_comb begin
            if (cap_en && slot_sel[k]) work_nx = {work_q[W-2:0], sdata_in};
            else                       work_nx = work_q;
        end

        always_ff @(negedge bit_clk) begin
            if (rst) begin
                work_q <= '0;
                hold_q <= '0;
            end else begin
                work_q <= work_nx;
                if (last_bit) hold_q <= work_nx;
            end
        end

        if (k == 0) begin : g_tag
            assign tag_slot = hold_q;
        end else begin : g_data
            assign data_slots[(k-1)*DATA_W +: DATA_W] = hold_q;
        end
    end

    always_ff @(negedge bit_clk) begin
        if (rst) frame_done <= 1'b0;
        else     frame_done <= last_bit;
    end

    assert_done_single_R6: assert property (@(negedge bit_clk) disable iff (rst)
        frame_done |=> !frame_done);
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
    parameter int TAG_W  = 16,
    parameter int DATA_W = 20,
    parameter int N_DATA = 12
) (
    input  logic                     bit_clk,
    input  logic                     rst,
    input  logic                     sync_in,
    input  logic                     sdata_in,
    output logic [TAG_W-1:0]         tag_slot,
    output logic [N_DATA*DATA_W-1:0] data_slots,
    output logic                     frame_valid,
    output logic [N_DATA-1:0]        slot_valid,
    output logic                     frame_done,
    output logic                     frame_err
);
    logic              cap_en, last_bit;
    logic [N_DATA:0]   slot_sel;

    tdm_rx_tracker #(.TAG_W(TAG_W), .DATA_W(DATA_W), .N_DATA(N_DATA)) u_tracker (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .cap_en    (cap_en),
        .slot_sel  (slot_sel),
        .last_bit  (last_bit),
        .frame_err (frame_err)
    );

    tdm_rx_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W), .N_DATA(N_DATA)) u_capture (
        .bit_clk    (bit_clk),
        .rst        (rst),
        .sdata_in   (sdata_in),
        .cap_en     (cap_en),
        .slot_sel   (slot_sel),
        .last_bit   (last_bit),
        .tag_slot   (tag_slot),
        .data_slots (data_slots),
        .frame_done (frame_done)
    );

    assign frame_valid = tag_slot[TAG_W-1];
    for (genvar k = 1; k <= N_DATA; k++) begin : g_mask
        assign slot_valid[k-1] = tag_slot[TAG_W-1-k];
    end

    assert_hold_between_frames_R7: assert property (@(negedge bit_clk) disable iff (rst)
        !frame_done |-> ($stable(tag_slot) && $stable(data_slots)));
    assert_one_hot_owner_R2: assert property (@(negedge bit_clk) disable iff (rst)
        cap_en |-> $onehot0(slot_sel) && (slot_sel != '0));
endmodule

// File: tb/tdm_frame_rx_bench.sv
module tdm_frame_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic         bit_clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_in = 1'b0;
    logic         sdata_in = 1'b0;
    logic [15:0]  tag_slot;
    logic [239:0] data_slots;
    logic         frame_valid;
    logic [11:0]  slot_valid;
    logic         frame_done;
    logic         frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    bit summary_done = 1'b0;

    logic [15:0] f_tag;
    logic [19:0] f_dat [1:12];

    tdm_frame_rx u_tdm_frame_rx (
        .bit_clk(bit_clk), .rst(rst), .sync_in(sync_in), .sdata_in(sdata_in),
        .tag_slot(tag_slot), .data_slots(data_slots), .frame_valid(frame_valid),
        .slot_valid(slot_valid), .frame_done(frame_done), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    always @(posedge bit_clk) if (frame_done === 1'b1) done_cnt++;

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
    end

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input int i);
        int k, off;
        if (i < 16) return f_tag[15-i];
        k   = 1 + (i - 16) / 20;
        off = (i - 16) % 20;
        return f_dat[k][19-off];
    endfunction

    function automatic logic [239:0] exp_data();
        logic [239:0] d;
        for (int k = 1; k <= 12; k++) d[(k-1)*20 +: 20] = f_dat[k];
        return d;
    endfunction

    function automatic logic [11:0] exp_mask();
        logic [11:0] m;
        for (int j = 0; j < 12; j++) m[j] = f_tag[14-j];
        return m;
    endfunction

    task automatic set_pattern(input int p);
        for (int k = 1; k <= 12; k++) begin
            case (p)
                0: f_dat[k] = {4'(k), 16'hC3A5 ^ 16'(k * 16'h0111)};
                1: f_dat[k] = 20'h80000 >> (k - 1);
                2: f_dat[k] = (k <= 4) ? {4'hF, 12'h0, 4'(k)} : 20'h0;
                default: f_dat[k] = 20'h5A5A5 ^ 20'(k);
            endcase
        end
        case (p)
            0: f_tag = 16'hFFF8;
            1: f_tag = 16'h8000;
            2: f_tag = 16'hF000;
            default: f_tag = 16'h5555;
        endcase
    endtask

    task automatic drive_bits(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(posedge bit_clk); #1;
            sync_in  = (i < 8);
            sdata_in = frame_bit(i);
        end
    endtask

    task automatic go_idle();
        @(posedge bit_clk); #1;
        sync_in = 1'b0; sdata_in = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        check({req, " tag"},   256'(tag_slot),    256'(f_tag));
        check({req, " data"},  256'(data_slots),  256'(exp_data()));
        check("R9 frame_valid", 256'(frame_valid), 256'(f_tag[15]));
        check("R9 slot_valid",  256'(slot_valid),  256'(exp_mask()));
    endtask

    // single frame: strobe due at the rising edge right after the last drive
    task automatic t_frame(input int p, input string req);
        set_pattern(p);
        drive_bits(256);
        go_idle();
        check("R6 done high", 256'(frame_done), 256'(1));
        check_outputs(req);
        @(posedge bit_clk); #1;
        check("R6 done one period", 256'(frame_done), 256'(0));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge bit_clk);
        #1;
        check("R1 done", 256'(frame_done), 256'(0));
        check("R1 err",  256'(frame_err),  256'(0));
        check("R1 tag",  256'(tag_slot),   256'(0));
        check("R1 data", 256'(data_slots), 256'(0));
        check("R1 mask", 256'({frame_valid, slot_valid}), 256'(0));
        rst = 1'b0;
    endtask

    task automatic t_pre_sync_ignored();
        int c0 = done_cnt;
        for (int i = 0; i < 300; i++) begin
            @(posedge bit_clk); #1;
            sync_in = 1'b0; sdata_in = 1'(i % 3 == 0);
        end
        go_idle();
        check("R5 no frame before sync", 256'(done_cnt - c0), 256'(0));
        check("R5 outputs untouched", 256'(data_slots), 256'(0));
    endtask

    task automatic t_hold_idle();
        logic [239:0] d0 = data_slots;
        logic [15:0]  t0 = tag_slot;
        int c0 = done_cnt;
        for (int i = 0; i < 300; i++) begin
            @(posedge bit_clk); #1;
            sync_in = 1'b0; sdata_in = 1'(i % 2);
        end
        go_idle();
        check("R7 data held", 256'(data_slots), 256'(d0));
        check("R7 tag held",  256'(tag_slot),   256'(t0));
        check("R7 no strobe", 256'(done_cnt - c0), 256'(0));
    endtask

    task automatic t_back_to_back();
        int c0 = done_cnt;
        set_pattern(1);
        drive_bits(256);
        set_pattern(2);
        drive_bits(256);
        go_idle();
        @(posedge bit_clk); #1;
        check("R11 two strobes", 256'(done_cnt - c0), 256'(2));
        check_outputs("R11 R8 second frame");
    endtask

    task automatic t_early_sync();
        int c0;
        check("R12 err clear before", 256'(frame_err), 256'(0));
        c0 = done_cnt;
        set_pattern(3);
        drive_bits(100);
        set_pattern(0);
        drive_bits(256);
        go_idle();
        @(posedge bit_clk); #1;
        check("R10 one strobe", 256'(done_cnt - c0), 256'(1));
        check("R10 err set", 256'(frame_err), 256'(1));
        check_outputs("R10 restarted frame");
        t_frame(1, "R12 good frame after error");
        check("R12 err sticky", 256'(frame_err), 256'(1));
        t_reset();
        check("R12 err cleared by reset", 256'(frame_err), 256'(0));
    endtask

    initial begin
        t_reset();
        t_pre_sync_ignored();
        t_frame(0, "R2 R3 R4 pattern0");
        t_frame(1, "R3 walking msb");
        t_frame(3, "R2 pattern3");
        t_frame(2, "R8 zero slots");
        t_hold_idle();
        t_back_to_back();
        t_early_sync();
        summary();
    end
endmodule